// File: doc/BRIEF.md
# Serial-Linked Determinant Processing Element

This block is one cell of a grid solver for linear systems that avoids division. It gets everything over a one-bit serial input qualified by a frame strobe. The controller first gives the cell an identity word. It then delivers four signed operands, called a, b, c and d. Once all four are present, the cell forms the 2x2 cross product a·d − b·c.

The cell has one signed multiplier and one subtractor. It runs them over three consecutive cycles and keeps every intermediate value in an eight-entry register file. The four operand slots, the two products and the difference are rewritten on every computation. The identity slot is written once and then holds its value.

The result goes back over a one-bit serial output. The identity word is sent first, so whoever collects the words can tell which grid position produced each one. A one-cycle flag marks the cycle in which a new result is ready. A second one-cycle flag reports operand frames that were refused because no identity had yet been assigned.

Top module: `pe_det_node`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `tx_bit`, `tx_frame`, `res_valid` and `id_error` are all 0.
- R2: An input frame is 67 consecutive cycles with `rx_frame` high. Bits arrive least significant first: a 3-bit tag, then a 64-bit payload. If the strobe falls before the 67th bit, the frame is discarded with no effect.
- R3: Tag 3'b100 carries the identity word. The first such frame after reset sets the identity. Every later identity frame is ignored.
- R4: Tags 3'b000, 3'b001, 3'b010 and 3'b011 load operand a, b, c and d respectively. Only the low 32 bits of the payload are used, as a two's complement value. The upper 32 bits have no effect.
- R5: An operand frame that completes while no identity is set is dropped and does not count toward a computation. It drives `id_error` high for exactly the one cycle after the edge that sampled its last bit.
- R6: A computation starts once each of the four slots has been written since the previous start. Rewriting a slot counts once and keeps the latest value. The result is a·d − b·c, reduced to 64-bit two's complement.
- R7: If the last bit of the completing operand frame is sampled at edge E and the cell is idle, then `res_valid` and `tx_frame` both go high after edge E+3. `res_valid` stays high for that one cycle only.
- R8: An output frame keeps `tx_frame` high for exactly 128 cycles. `tx_bit` carries the 64-bit identity first, then the 64-bit result, each least significant bit first.
- R9: After a start, all four slots must be written again before the next computation. Writing only some of them starts nothing.
- R10: Input frames with tags 3'b101, 3'b110 or 3'b111 change nothing and raise no flag.
- R11: If `rx_frame` stays high past the 67th bit, the extra bits are ignored until the strobe goes low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial input data |
| rx_frame | input | 1 | High for each bit of an input frame |
| tx_bit | output | 1 | Serial output data |
| tx_frame | output | 1 | High for each bit of an output frame |
| res_valid | output | 1 | One-cycle pulse when a new result is ready |
| id_error | output | 1 | One-cycle pulse when an operand frame is refused for lack of identity |

## Verification
The hardest states to reach from the ports are those around the edges of a frame. These include a strobe that drops a few bits early and a strobe that stays high past the payload. They also include an operand rewritten before the set is complete, and a partial set offered right after a computation has cleared the slot record. The stimulus drives each frame bit by bit with a chosen length and interleaves full, aborted, overlong and reserved-tag frames inside operand sets. After each such frame it waits and checks that no output frame appears too early. A per-cycle model in the bench predicts every output pin, so any timing slip shows up on the cycle it occurs.

// File: rtl/pe_det_pkg.sv
package pe_det_pkg;
  localparam int PE_NREG = 8;
  localparam int PE_AW   = $clog2(PE_NREG);
  localparam int PE_OPS  = 4;

  // register file slots; the arithmetic sequence depends on these positions
  localparam logic [PE_AW-1:0] RF_A    = 3'd0;
  localparam logic [PE_AW-1:0] RF_B    = 3'd1;
  localparam logic [PE_AW-1:0] RF_C    = 3'd2;
  localparam logic [PE_AW-1:0] RF_D    = 3'd3;
  localparam logic [PE_AW-1:0] RF_P0   = 3'd4;
  localparam logic [PE_AW-1:0] RF_P1   = 3'd5;
  localparam logic [PE_AW-1:0] RF_DIFF = 3'd6;
  localparam logic [PE_AW-1:0] RF_ID   = 3'd7;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_MUL1,
    SQ_SUB,
    SQ_TX
  } seq_state_t;
endpackage

// File: rtl/pe_rx.sv
module pe_rx #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_frame,
  output logic              commit_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int LEN = TAG_W + DATA_W;
  localparam int CW  = $clog2(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0]  cnt_q, cnt_d;
  logic           hold_q, hold_d;
  logic [LEN-2:0] sh_q;
  logic           sh_en;
  logic [LEN-1:0] full;

  always_comb begin
    cnt_d    = cnt_q;
    hold_d   = hold_q;
    sh_en    = 1'b0;
    commit_o = 1'b0;
    if (!rx_frame) begin
      cnt_d  = '0;
      hold_d = 1'b0;
    end else if (!hold_q) begin
      if (cnt_q == LAST) begin
        cnt_d    = '0;
        hold_d   = 1'b1;
        commit_o = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        sh_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      if (sh_en) sh_q <= {rx_bit, sh_q[LEN-2:1]};
    end
  end

  assign full   = {rx_bit, sh_q};
  assign tag_o  = full[TAG_W-1:0];
  assign data_o = full[LEN-1:TAG_W];

  // a frame can only complete if the strobe was already high one cycle earlier
  p_commit_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(rx_frame));
endmodule

// File: rtl/pe_regfile.sv
module pe_regfile #(
  parameter int W      = 64,
  parameter int N      = 8,
  parameter int OPS    = 4,
  parameter int ID_IDX = N - 1,
  localparam int AW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wa_en,
  input  logic [AW-1:0] wa_addr,
  input  logic [W-1:0]  wa_data,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  input  logic [W-1:0]  wb_data,
  input  logic [AW-1:0] rd0_addr,
  input  logic [AW-1:0] rd1_addr,
  output logic [W-1:0]  rd0_data,
  output logic [W-1:0]  rd1_data,
  output logic [W-1:0]  id_word,
  output logic          id_valid
);
  logic [N-1:0][W-1:0] ent;
  logic                id_set_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic         we;
    logic [W-1:0] d;
    logic [W-1:0] q;
    if (g == ID_IDX) begin : g_idslot
      assign we = wa_en && (wa_addr == AW'(g)) && !id_set_q;
      assign d  = wa_data;
    end else if (g < OPS) begin : g_opslot
      assign we = wa_en && (wa_addr == AW'(g));
      assign d  = wa_data;
    end else begin : g_workslot
      assign we = wb_en && (wb_addr == AW'(g));
      assign d  = wb_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
    end
    assign ent[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) id_set_q <= 1'b0;
    else if (wa_en && (wa_addr == AW'(ID_IDX))) id_set_q <= 1'b1;
  end

  assign rd0_data = ent[rd0_addr];
  assign rd1_data = ent[rd1_addr];
  assign id_word  = ent[ID_IDX];
  assign id_valid = id_set_q;

  p_id_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && $past(id_valid)) |-> $stable(id_word));
endmodule

// File: rtl/pe_arith.sv
module pe_arith #(
  parameter int W    = 64,
  parameter int OP_W = 32
) (
  input  logic [W-1:0] opx,
  input  logic [W-1:0] opy,
  input  logic         do_sub,
  output logic [W-1:0] res
);
  localparam int PW = 2 * OP_W;

  logic signed [PW-1:0] prod;
  logic        [W-1:0]  prod_w;

  assign prod = $signed(opx[OP_W-1:0]) * $signed(opy[OP_W-1:0]);

  if (W > PW) begin : g_ext
    assign prod_w = {{(W-PW){prod[PW-1]}}, prod};
  end else begin : g_fit
    assign prod_w = prod[W-1:0];
  end

  assign res = do_sub ? (opx - opy) : prod_w;
endmodule

// File: rtl/pe_tx.sv
module pe_tx #(
  parameter int FW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] load_word,
  output logic          tx_bit,
  output logic          tx_busy,
  output logic          last
);
  localparam int CW = $clog2(FW);
  localparam logic [CW-1:0] LAST = CW'(FW - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [FW-1:0] sh_q, sh_d;
  logic          sh_en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    sh_en  = 1'b0;
    if (load) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      sh_d   = load_word;
      sh_en  = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        sh_d  = sh_q >> 1;
        sh_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (sh_en) sh_q <= sh_d;
    end
  end

  assign tx_bit  = sh_q[0];
  assign tx_busy = busy_q;
  assign last    = busy_q && (cnt_q == LAST);

  p_frame_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));
  p_load_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/pe_det_node.sv
module pe_det_node
  import pe_det_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int OP_W   = 32,
  parameter int TAG_W  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic rx_frame,
  output logic tx_bit,
  output logic tx_frame,
  output logic res_valid,
  output logic id_error
);
  localparam logic [TAG_W-1:0] TAG_ID  = TAG_W'(4);
  localparam logic [TAG_W-1:0] TAG_OPS = TAG_W'(PE_OPS);

  logic              rx_commit;
  logic [TAG_W-1:0]  rx_tag;
  logic [WORD_W-1:0] rx_data;
  logic              is_id, is_op, op_ok, id_wr;
  logic [WORD_W-1:0] op_sext;

  logic              wa_en, wb_en;
  logic [PE_AW-1:0]  wa_addr, wb_addr, rd0_addr, rd1_addr;
  logic [WORD_W-1:0] wa_data, rd0_data, rd1_data, id_word, arith_res;
  logic              id_valid, do_sub;

  logic              tx_load, tx_last, tx_busy;

  seq_state_t          state_q, state_d;
  logic [PE_OPS-1:0]   mask_q, mask_d, mask_set;
  logic                mask_clr;
  logic                err_q, err_d, valid_q, valid_d;

  pe_rx #(.TAG_W(TAG_W), .DATA_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_frame(rx_frame),
    .commit_o(rx_commit), .tag_o(rx_tag), .data_o(rx_data)
  );

  pe_regfile #(.W(WORD_W), .N(PE_NREG), .OPS(PE_OPS), .ID_IDX(int'(RF_ID))) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(arith_res),
    .rd0_addr(rd0_addr), .rd1_addr(rd1_addr),
    .rd0_data(rd0_data), .rd1_data(rd1_data),
    .id_word(id_word), .id_valid(id_valid)
  );

  pe_arith #(.W(WORD_W), .OP_W(OP_W)) u_alu (
    .opx(rd0_data), .opy(rd1_data), .do_sub(do_sub), .res(arith_res)
  );

  pe_tx #(.FW(2*WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_word({arith_res, id_word}),
    .tx_bit(tx_bit), .tx_busy(tx_busy), .last(tx_last)
  );

  // receive-side decode: identity and operand slots write through port A
  always_comb begin
    is_id    = (rx_tag == TAG_ID);
    is_op    = (rx_tag < TAG_OPS);
    id_wr    = rx_commit && is_id;
    op_ok    = rx_commit && is_op && id_valid;
    op_sext  = {{(WORD_W-OP_W){rx_data[OP_W-1]}}, rx_data[OP_W-1:0]};
    wa_en    = id_wr || op_ok;
    wa_addr  = id_wr ? RF_ID : {1'b0, rx_tag[1:0]};
    wa_data  = id_wr ? rx_data : op_sext;
    mask_set = op_ok ? (PE_OPS'(1) << rx_tag[1:0]) : '0;
    err_d    = rx_commit && is_op && !id_valid;
  end

  // compute sequencer: products in two cycles, difference in the third
  always_comb begin
    state_d  = state_q;
    wb_en    = 1'b0;
    wb_addr  = RF_P0;
    rd0_addr = RF_A;
    rd1_addr = RF_D;
    do_sub   = 1'b0;
    tx_load  = 1'b0;
    mask_clr = 1'b0;
    valid_d  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (&mask_q) begin
          wb_en    = 1'b1;
          wb_addr  = RF_P0;
          mask_clr = 1'b1;
          state_d  = SQ_MUL1;
        end
      end
      SQ_MUL1: begin
        rd0_addr = RF_B;
        rd1_addr = RF_C;
        wb_en    = 1'b1;
        wb_addr  = RF_P1;
        state_d  = SQ_SUB;
      end
      SQ_SUB: begin
        rd0_addr = RF_P0;
        rd1_addr = RF_P1;
        do_sub   = 1'b1;
        wb_en    = 1'b1;
        wb_addr  = RF_DIFF;
        tx_load  = 1'b1;
        valid_d  = 1'b1;
        state_d  = SQ_TX;
      end
      SQ_TX: begin
        if (tx_last) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
    mask_d = (mask_clr ? '0 : mask_q) | mask_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      mask_q  <= '0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      err_q   <= err_d;
      valid_q <= valid_d;
    end
  end

  assign tx_frame  = tx_busy;
  assign res_valid = valid_q;
  assign id_error  = err_q;

  p_valid_opens_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (tx_frame && !$past(tx_frame)));
  p_tx_rise_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_frame) |-> res_valid);
  p_err_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    id_error |=> !id_error);
  p_start_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_MUL1) |-> ($past(mask_q) == '1));
  p_busy_needs_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SQ_IDLE) |-> id_valid);
endmodule

// File: tb/sim_pe_det_node.sv
module sim_pe_det_node;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit = 1'b0;
  logic rx_frame = 1'b0;
  wire  tx_bit, tx_frame, res_valid, id_error;

  always #10 clk = ~clk;

  pe_det_node u0 (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_frame(rx_frame),
    .tx_bit(tx_bit), .tx_frame(tx_frame), .res_valid(res_valid), .id_error(id_error)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] det_of(input logic [31:0] a, b, c, d);
    longint pa, pb;
    pa = longint'($signed(a)) * longint'($signed(d));
    pb = longint'($signed(b)) * longint'($signed(c));
    return 64'(pa - pb);
  endfunction

  // ---------------- behavioural reference, advanced on every rising edge
  int           m_cnt, m_phase, m_txi;
  bit           m_hold, m_idset;
  logic [66:0]  m_bits;
  logic [63:0]  m_id;
  logic [31:0]  m_op [4];
  logic [3:0]   m_mask;
  logic [31:0]  la, lb, lc, ld;
  logic [127:0] m_word;
  bit           e_valid, e_err, e_txf, e_txb;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_txi = 0; m_hold = 0; m_idset = 0;
      m_bits = '0; m_id = '0; m_mask = '0; m_word = '0;
      for (int i = 0; i < 4; i++) m_op[i] = '0;
      e_valid = 0; e_err = 0; e_txf = 0; e_txb = 0;
    end else begin
      e_valid = 0;
      e_err = 0;
      if (m_phase == 0 && m_mask == 4'hF) begin
        la = m_op[0]; ld = m_op[3]; m_mask = '0; m_phase = 1;
      end else if (m_phase == 1) begin
        lb = m_op[1]; lc = m_op[2]; m_phase = 2;
      end else if (m_phase == 2) begin
        m_word = {det_of(la, lb, lc, ld), m_id}; m_txi = 0; m_phase = 3; e_valid = 1;
      end else if (m_phase == 3) begin
        if (m_txi == 127) m_phase = 0; else m_txi++;
      end
      if (!rx_frame) begin
        m_cnt = 0; m_hold = 0;
      end else if (!m_hold) begin
        m_bits[m_cnt] = rx_bit;
        if (m_cnt == 66) begin
          m_cnt = 0; m_hold = 1;
          if (m_bits[2:0] == 3'b100) begin
            if (!m_idset) begin m_id = m_bits[66:3]; m_idset = 1; end
          end else if (m_bits[2] == 1'b0) begin
            if (!m_idset) e_err = 1;
            else begin m_op[m_bits[1:0]] = m_bits[34:3]; m_mask[m_bits[1:0]] = 1'b1; end
          end
        end else m_cnt++;
      end
      e_txf = (m_phase == 3);
      e_txb = e_txf ? m_word[m_txi] : 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(tx_frame == e_txf, "R8", "tx_frame per cycle", 128'(tx_frame), 128'(e_txf));
      if (e_txf) check(tx_bit == e_txb, "R8", "tx_bit per cycle", 128'(tx_bit), 128'(e_txb));
      check(res_valid == e_valid, "R7", "res_valid per cycle", 128'(res_valid), 128'(e_valid));
      check(id_error == e_err, "R5", "id_error per cycle", 128'(id_error), 128'(e_err));
    end
  end

  // ---------------- stimulus helpers
  task automatic send_frame(input logic [2:0] tag, input logic [63:0] data, input int nbits);
    logic [66:0] f;
    f = {data, tag};
    rx_frame = 1'b0;
    @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rx_frame = 1'b1;
      rx_bit = (i < 67) ? f[i] : 1'b1;
      @(negedge clk);
    end
    rx_frame = 1'b0;
    rx_bit = 1'b0;
  endtask

  task automatic send_op(input int slot, input logic [31:0] v);
    send_frame(3'(slot), {32'hC0DE_0000 ^ 32'(slot * 3 + 1), v}, 67);
  endtask

  task automatic expect_idle(input string req, input int cycles);
    bit seen;
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tx_frame || res_valid) seen = 1;
    end
    check(!seen, req, "no output frame expected", 128'(seen), 128'(0));
  endtask

  // called right after the last operand frame's final bit was sampled
  task automatic check_result(input logic [63:0] id, input logic [63:0] det, input string req);
    logic [127:0] cap;
    @(negedge clk);
    check(res_valid == 0, "R7", "res_valid at E+1", 128'(res_valid), 128'(0));
    @(negedge clk);
    check(res_valid == 0, "R7", "res_valid at E+2", 128'(res_valid), 128'(0));
    @(negedge clk);
    check(res_valid && tx_frame, "R7", "valid and frame at E+3",
          128'({res_valid, tx_frame}), 128'(2'b11));
    for (int i = 0; i < 128; i++) begin
      cap[i] = tx_bit;
      @(negedge clk);
    end
    check(tx_frame == 0, "R8", "frame ends after 128 bits", 128'(tx_frame), 128'(0));
    check(cap[63:0] == id, "R3", "identity header", 128'(cap[63:0]), 128'(id));
    check(cap[127:64] == det, req, "determinant", 128'(cap[127:64]), 128'(det));
  endtask

  localparam logic [63:0] ID1 = 64'h0123_4567_89AB_CDEF;
  localparam logic [63:0] ID2 = 64'hFEDC_0000_1111_2222;

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
          failures++;
          $display("FAIL R6 watchdog actual=running expected=done");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    // R1: reset state
    repeat (3) @(negedge clk);
    check({tx_bit, tx_frame, res_valid, id_error} == 4'b0, "R1", "outputs in reset",
          128'({tx_bit, tx_frame, res_valid, id_error}), 128'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check({tx_bit, tx_frame, res_valid, id_error} == 4'b0, "R1", "outputs after release",
          128'({tx_bit, tx_frame, res_valid, id_error}), 128'(0));

    // R5: operands before identity are refused with a one-cycle flag
    send_op(0, 32'd5);
    check(id_error == 1, "R5", "flag after refused operand", 128'(id_error), 128'(1));
    @(negedge clk);
    check(id_error == 0, "R5", "flag lasts one cycle", 128'(id_error), 128'(0));
    send_op(1, 32'd6);
    send_op(2, 32'd7);
    send_op(3, 32'd8);
    send_frame(3'b100, ID1, 67);
    expect_idle("R5", 20);

    // R3: a second identity frame is ignored
    send_frame(3'b100, ID2, 67);

    // R4 R6: basic determinant, upper payload bits nonzero
    send_op(0, 32'd7); send_op(1, 32'd3); send_op(2, 32'd2); send_op(3, 32'd5);
    check_result(ID1, det_of(7, 3, 2, 5), "R6");

    // R4: signed extremes
    send_op(0, 32'hFFFF_FFFC); send_op(1, 32'h7FFF_FFFF);
    send_op(2, 32'h7FFF_FFFF); send_op(3, 32'h8000_0000);
    check_result(ID1, det_of(32'hFFFF_FFFC, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000), "R4");

    // R9: rewrite counts once and keeps the latest value
    send_op(0, 32'd100); send_op(1, 32'd6); send_op(2, 32'd4); send_op(0, 32'd9);
    expect_idle("R9", 10);
    send_op(3, 32'hFFFF_FFFE);
    check_result(ID1, det_of(9, 6, 4, 32'hFFFF_FFFE), "R9");

    // R9: a partial set after a start does nothing
    send_op(2, 32'd1);
    expect_idle("R9", 10);
    send_op(0, 32'd3); send_op(1, 32'd2); send_op(3, 32'd10);
    check_result(ID1, det_of(3, 2, 1, 10), "R9");

    // R2: an aborted frame has no effect
    send_op(0, 32'd11); send_op(1, 32'hFFFF_FFFB); send_op(2, 32'd4);
    send_frame(3'b011, 64'd999, 40);
    expect_idle("R2", 10);
    send_op(3, 32'd6);
    check_result(ID1, det_of(11, 32'hFFFF_FFFB, 4, 6), "R2");

    // R10: reserved tags change nothing
    send_op(0, 32'd1); send_op(1, 32'd2); send_op(2, 32'd3);
    send_frame(3'b101, 64'd77, 67);
    check(id_error == 0, "R10", "no flag for reserved tag", 128'(id_error), 128'(0));
    send_frame(3'b111, 64'hFFFF_FFFF_FFFF_FFFF, 67);
    expect_idle("R10", 10);
    send_op(3, 32'd4);
    check_result(ID1, det_of(1, 2, 3, 4), "R10");

    // R11: an overlong strobe ignores the extra bits
    send_op(0, 32'hFFFF_FFFF); send_op(1, 32'hFFFF_FFFF);
    send_frame(3'b010, {32'h0, 32'd8}, 90);
    expect_idle("R11", 5);
    send_op(3, 32'hFFFF_FFFD);
    check_result(ID1, det_of(32'hFFFF_FFFF, 32'hFFFF_FFFF, 8, 32'hFFFF_FFFD), "R11");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule